// File: doc/BRIEF.md
# Masked-Access GPIO Port Controller

This block is one eight-pin general-purpose I/O port behind a simple memory-mapped register bus. Each pin has its own settings for direction, output data, alternate-function hand-over and interrupt detection. Software changes any subset of pins in a single write, because the address of a data access carries a per-pin mask.

Pin inputs pass through a two-flop synchroniser. Edge events on a pin are latched until software clears them. Level events are not latched: they follow the synchronised pin level. Raw and masked status can be read at any time, and one interrupt request line combines every unmasked pin.

Reads are combinational from the address. Writes take effect on the rising clock edge while the write strobe is high. Accesses with address bits [1:0] not zero are ignored, and such reads return zero.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset every register is zero. All pins are inputs under software control, with edge sensing, falling polarity and interrupts masked. `pin_oe`, `pin_out` and `irq` are 0.
- R2: Addresses 0x000 to 0x3FC reach the output-data register, and address bits [9:2] form a pin mask. A write there changes only the pins whose mask bit is 1.
- R3: A read in the data window returns a value for each pin whose mask bit is 1, and 0 for every other pin. An output pin returns its output-data bit. An input pin returns its synchronised level, which follows `pin_in` two clock edges after `pin_in` changes.
- R4: While bit n of the alternate-function register is 0, `pin_oe[n]` equals bit n of the direction register (1 = output) and `pin_out[n]` equals output-data bit n.
- R5: While bit n of the alternate-function register is 1, `pin_out[n]` is taken from `periph_out[n]` and `pin_oe[n]` from `periph_oe[n]`.
- R6: For a pin in edge mode (sense bit 0) with its both-edges bit at 0, the raw status bit latches on a rising edge when its polarity bit is 1, or on a falling edge when it is 0. The opposite edge is ignored. The bit latches whether or not the pin is enabled. It is visible on the third clock edge after `pin_in` changes.
- R7: With its both-edges bit at 1, an edge-mode pin latches on either edge, whatever its polarity bit.
- R8: With its sense bit at 1, the pin's raw status is 1 while the synchronised pin level equals its polarity bit (1 = high, 0 = low) and 0 otherwise. It is not latched, and a clear write does not change it.
- R9: Writing the clear register clears the latched edge bits where the written data is 1 and leaves bits written 0 untouched. An edge detected on the same edge as the clear write keeps that bit set.
- R10: Masked status is raw status ANDed with the enable register (1 = unmasked). `irq` is 1 when any masked status bit is 1.
- R11: Register map: direction 0x400, sense 0x404, both-edges 0x408, polarity 0x40C, enable 0x410, raw status 0x414 (read-only), masked status 0x418 (read-only), clear 0x41C (write-only, reads 0), alternate-function 0x420. Writable configuration registers read back what was written. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| pin_in | input | 8 | Levels seen at the pins |
| pin_out | output | 8 | Output values driven to the pins |
| pin_oe | output | 8 | Per-pin output enable |
| periph_out | input | 8 | Output values from the peripheral side |
| periph_oe | input | 8 | Output enables from the peripheral side |
| irq | output | 1 | Combined interrupt request |

## Verification
A write to the clear register and a newly detected edge on the same pin can fall on the same clock edge. The bench provokes this by changing a pin and then timing the clear write so the register takes it on the third clock edge after the change, which is exactly when the edge is latched. It then reads raw status: the bit must still be set, so the new event is not lost. Separate cases check that a clear with no competing edge empties the bit, and that a clear write of 0 has no effect.

// File: rtl/gpio_mask_port.sv
module gpio_mask_port #(
  parameter int NPIN = 8,
  parameter int AW   = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic [NPIN-1:0] bus_wdata,
  output logic [NPIN-1:0] bus_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  input  logic [NPIN-1:0] periph_out,
  input  logic [NPIN-1:0] periph_oe,
  output logic            irq
);

  localparam int MSB_LO = NPIN + 2;

  localparam logic [3:0] IX_DIR = 4'd0, IX_SNS = 4'd1, IX_BTH = 4'd2, IX_POL = 4'd3,
                         IX_IEN = 4'd4, IX_RAW = 4'd5, IX_MSK = 4'd6, IX_CLR = 4'd7,
                         IX_ALT = 4'd8;

  logic [NPIN-1:0] dout, dir, sns, bth, pol, ien, alt;
  logic [NPIN-1:0] sync1, sync2, prev, edge_q;
  logic [NPIN-1:0] rise, fall, evt, lvl, raw, msk, dmask, rd_pin, clr_bits;

  wire aligned  = bus_addr[1:0] == 2'b00;
  wire data_sel = aligned && bus_addr[AW-1:MSB_LO] == '0;
  wire cfg_sel  = aligned && bus_addr[AW-1:MSB_LO] == 1 && bus_addr[MSB_LO-1:6] == '0;
  wire [3:0] idx = bus_addr[5:2];
  wire data_wr  = bus_wr && data_sel;
  wire cfg_wr   = bus_wr && cfg_sel;
  wire clr_wr   = cfg_wr && idx == IX_CLR;

  assign dmask    = bus_addr[MSB_LO-1:2];
  assign clr_bits = clr_wr ? bus_wdata : '0;

  assign rise = sync2 & ~prev;
  assign fall = ~sync2 & prev;
  assign evt  = ~sns & ((bth & (rise | fall)) | (~bth & pol & rise) | (~bth & ~pol & fall));
  assign lvl  = sns & ~(sync2 ^ pol);
  assign raw  = lvl | (~sns & edge_q);
  assign msk  = raw & ien;
  assign irq  = |msk;

  assign pin_out = (alt & periph_out) | (~alt & dout);
  assign pin_oe  = (alt & periph_oe)  | (~alt & dir);
  assign rd_pin  = (dir & dout) | (~dir & sync2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {sync1, sync2, prev, edge_q} <= '0;
      {dout, dir, sns, bth, pol, ien, alt} <= '0;
    end else begin
      sync1  <= pin_in;
      sync2  <= sync1;
      prev   <= sync2;
      edge_q <= (edge_q & ~clr_bits) | evt;
      if (data_wr) dout <= (dout & ~dmask) | (bus_wdata & dmask);
      if (cfg_wr) begin
        case (idx)
          IX_DIR:  dir <= bus_wdata;
          IX_SNS:  sns <= bus_wdata;
          IX_BTH:  bth <= bus_wdata;
          IX_POL:  pol <= bus_wdata;
          IX_IEN:  ien <= bus_wdata;
          IX_ALT:  alt <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (data_sel) bus_rdata = rd_pin & dmask;
    else if (cfg_sel) begin
      case (idx)
        IX_DIR:  bus_rdata = dir;
        IX_SNS:  bus_rdata = sns;
        IX_BTH:  bus_rdata = bth;
        IX_POL:  bus_rdata = pol;
        IX_IEN:  bus_rdata = ien;
        IX_RAW:  bus_rdata = raw;
        IX_MSK:  bus_rdata = msk;
        IX_ALT:  bus_rdata = alt;
        default: bus_rdata = '0;
      endcase
    end
  end

  AST_DATA_UNMASKED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> ((dout & ~$past(dmask)) == ($past(dout) & ~$past(dmask)))); // R2

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && idx == IX_DIR) |=> $stable(dir)); // R4

  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((edge_q & $past(edge_q)) == $past(edge_q))); // R6

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && (bus_wdata & evt) == '0) |=> ((edge_q & $past(bus_wdata)) == '0)); // R9

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (ien != '0)); // R10

endmodule

// File: tb/gpio_mask_port_bench.sv
`timescale 1ns/1ps
module gpio_mask_port_bench;
  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_oe;
  logic [7:0] periph_out = '0, periph_oe = '0;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_mask_port u_gpio_mask_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .periph_out(periph_out),
    .periph_oe(periph_oe), .irq(irq));

  localparam logic [11:0] A_DIR = 12'h400, A_SNS = 12'h404, A_BTH = 12'h408,
    A_POL = 12'h40C, A_IEN = 12'h410, A_RAW = 12'h414, A_MSK = 12'h418,
    A_CLR = 12'h41C, A_ALT = 12'h420;

  // {mask, wdata, expected output data}
  localparam int NV = 6;
  localparam logic [23:0] VEC [NV] = '{
    24'hFF_A5_A5, 24'h0F_0A_AA, 24'hC3_00_28,
    24'h00_FF_28, 24'h81_FF_A9, 24'h3C_14_95 };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(A_DIR, r); chk("R1 dir", r, 8'h00);
    rd(A_ALT, r); chk("R1 alt", r, 8'h00);
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 pin_out", pin_out, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);

    wr(A_DIR, 8'hFF);
    chk("R4 oe all", pin_oe, 8'hFF);
    for (int i = 0; i < NV; i++) begin
      wr({2'b00, VEC[i][23:16], 2'b00}, VEC[i][15:8]);
      chk($sformatf("R2 vec%0d", i), pin_out, VEC[i][7:0]);
    end
    rd(12'h3FC, r); chk("R3 read full", r, 8'h95);
    rd(12'h03C, r); chk("R3 read low mask", r, 8'h05);
    rd(12'h3FE, r); chk("R3 misaligned read", r, 8'h00);

    wr(A_DIR, 8'h0F);
    chk("R4 oe partial", pin_oe, 8'h0F);
    periph_out = 8'h3C; periph_oe = 8'hF0;
    wr(A_ALT, 8'hF0);
    chk("R5 alt out", pin_out, 8'h35);
    chk("R5 alt oe", pin_oe, 8'hFF);
    wr(A_ALT, 8'h00);
    chk("R5 back to sw", pin_out, 8'h95);

    wr(A_DIR, 8'h00);
    pin_in = 8'h5A;
    settle(2);
    rd(12'h3C0, r); chk("R3 input read", r, 8'h50);

    pin_in = 8'h00; settle(4); wr(A_CLR, 8'hFF);
    rd(A_RAW, r); chk("R9 clear all", r, 8'h00);
    pin_in = 8'h01; settle(4);
    rd(A_RAW, r); chk("R6 wrong edge ignored", r, 8'h00);
    pin_in = 8'h00; settle(4);
    rd(A_RAW, r); chk("R6 falling latched while masked", r, 8'h01);
    rd(A_MSK, r); chk("R10 masked zero", r, 8'h00);
    chk("R10 irq low", {7'b0, irq}, 8'h00);
    wr(A_IEN, 8'h01);
    rd(A_MSK, r); chk("R10 masked set", r, 8'h01);
    chk("R10 irq high", {7'b0, irq}, 8'h01);
    wr(A_CLR, 8'h02);
    rd(A_RAW, r); chk("R9 zero bits no effect", r, 8'h01);
    wr(A_CLR, 8'h01);
    rd(A_RAW, r); chk("R9 clear bit", r, 8'h00);
    chk("R10 irq after clear", {7'b0, irq}, 8'h00);

    wr(A_POL, 8'h02);
    pin_in = 8'h02; settle(4);
    rd(A_RAW, r); chk("R6 rising latched", r, 8'h02);
    wr(A_CLR, 8'hFF);

    wr(A_BTH, 8'h04);
    pin_in = 8'h06; settle(4);
    rd(A_RAW, r); chk("R7 both rise", r, 8'h04);
    wr(A_CLR, 8'h04);
    pin_in = 8'h02; settle(4);
    rd(A_RAW, r); chk("R7 both fall", r, 8'h04);
    wr(A_CLR, 8'hFF);

    wr(A_SNS, 8'h08); wr(A_POL, 8'h0A);
    pin_in = 8'h0A; settle(3);
    rd(A_RAW, r); chk("R8 level high", r & 8'h08, 8'h08);
    wr(A_CLR, 8'h08);
    rd(A_RAW, r); chk("R8 clear no effect", r & 8'h08, 8'h08);
    pin_in = 8'h02; settle(3);
    rd(A_RAW, r); chk("R8 level follows", r & 8'h08, 8'h00);

    rd(A_SNS, r); chk("R11 sense readback", r, 8'h08);
    rd(A_BTH, r); chk("R11 both readback", r, 8'h04);
    rd(A_POL, r); chk("R11 pol readback", r, 8'h0A);
    rd(A_CLR, r); chk("R11 clear reads 0", r, 8'h00);
    rd(12'h440, r); chk("R11 unmapped", r, 8'h00);

    pin_in = 8'h03; settle(4); wr(A_CLR, 8'hFF);
    @(negedge clk);
    pin_in = 8'h02;
    @(posedge clk);
    @(posedge clk);
    wr(A_CLR, 8'h01);
    rd(A_RAW, r); chk("R9 edge beats clear", r & 8'h01, 8'h01);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule